// File: doc/BRIEF.md
# NAND Page Parity Signature Generator

This block builds a single-error-correcting parity signature over one page of NAND flash data while the data streams past, one byte or one 16-bit word per accepted cycle. It treats every data bit as having a global bit address inside the page. That address is made of the word's position in the page, followed by the bit's index inside the word. For each address bit it keeps two running parities. The "even" parity folds in every data bit whose address has a 0 in that position. The "odd" parity folds in every data bit whose address has a 1 there.

The low address bits come from the bit index inside the word, so they give column parities. The high address bits come from an internal position counter, so they give row parities. The boundary between the two moves with the bus width: three column levels for bytes, four for 16-bit words. Software compares the signature against the one stored in the spare area to locate a flipped bit. That comparison is outside this block. A pulse on `clr` starts a new page. The signature can be read at any time and covers every word accepted since the last clear.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, `ecc_out` is all zeros and the position counter is zero.
- R2: A `clr` pulse zeroes every parity bit and restarts the position counter at zero, taking effect on the next edge. When `clr` and `in_valid` are high in the same cycle, `clr` wins and the word is dropped.
- R3: With `wide`=0 (byte mode), levels 0..2 (packed bits 0..5) are column parities over bit index 0..7 of `in_data[7:0]`, and `in_data[15:8]` has no effect.
- R4: With `wide`=0, levels 3..11 (packed bits 6..23) are row parities taken from byte position bits 0..8 in the page.
- R5: With `wide`=1 (word mode), levels 0..3 (packed bits 0..7) are column parities over bit index 0..15 of `in_data`.
- R6: With `wide`=1, levels 4..11 (packed bits 8..23) are row parities taken from word position bits 0..7.
- R7: A cycle with `in_valid` and `clr` both low leaves `ecc_out` unchanged.
- R8: A word accepted at a clock edge is reflected in `ecc_out` right after that same edge, a latency of one cycle. Packing is `ecc_out[2L]` = even parity of level L and `ecc_out[2L+1]` = odd parity of level L.
- R9: For every level, even XOR odd equals the parity of all data bits accepted so far. All levels therefore agree on this value.
- R10: A 256-byte block in byte mode leaves level 11 odd (bit 23) at zero. A 128-byte block leaves levels 10 and 11 odd (bits 21 and 23) at zero.
- R11: The position counter wraps after a full page. In byte mode the 513th byte counts as position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Start a new page: zero the parities and the position |
| in_valid | input | 1 | `in_data` holds a word to accumulate |
| in_data | input | 16 | Data word; only bits 7:0 are used in byte mode |
| wide | input | 1 | 0 = byte mode, 1 = 16-bit word mode |
| ecc_out | output | 24 | Packed even/odd parity pairs, levels 0..11 |

## Verification
Every result, whether an accepted word, a clear or an idle cycle, is due exactly one clock edge after the cycle that presents it. There is no other pipeline stage. The driver applies inputs on the falling edge and queues the signature it expects after the next rising edge. The monitor pops one expected value per rising edge and compares it a short delay after that edge, so the queue order enforces the one-cycle latency. The bench's reference uses its own bit-address model, and separate direct checks on single bits cover the partial-block and wrap cases.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int BUS_W      = 16;
  localparam int NARROW_W   = BUS_W / 2;
  localparam int COL_WIDE   = $clog2(BUS_W);
  localparam int COL_NARROW = $clog2(NARROW_W);

  // Parity of the data bits whose in-word index has bit k equal to 'odd'.
  function automatic logic col_half(input logic [BUS_W-1:0] d, input logic wide,
                                    input logic [1:0] k, input logic odd);
    logic r;
    logic [3:0] iv;
    r = 1'b0;
    for (int i = 0; i < BUS_W; i++) begin
      iv = 4'(i);
      if ((wide || i < NARROW_W) && (iv[k] == odd)) r = r ^ d[i];
    end
    return r;
  endfunction

  // Parity of the data bits that take part in the current mode.
  function automatic logic word_parity(input logic [BUS_W-1:0] d, input logic wide);
    return wide ? ^d : ^d[NARROW_W-1:0];
  endfunction
endpackage

// File: rtl/nand_word_counter.sv
module nand_word_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             advance,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (advance) cnt <= cnt + 1'b1;
  end

  // R11
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clr && cnt == LAST) |=> (cnt == '0));

  // R2
  clear_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/nand_col_parity.sv
module nand_col_parity
  import nand_ecc_pkg::*;
(
  input  logic [BUS_W-1:0]    data,
  input  logic                wide,
  output logic [COL_WIDE-1:0] col_e,
  output logic [COL_WIDE-1:0] col_o,
  output logic                wpar
);
  for (genvar k = 0; k < COL_WIDE; k++) begin : g_col
    assign col_e[k] = col_half(data, wide, 2'(k), 1'b0);
    assign col_o[k] = col_half(data, wide, 2'(k), 1'b1);
  end

  assign wpar = word_parity(data, wide);
endmodule

// File: rtl/nand_level_map.sv
module nand_level_map
  import nand_ecc_pkg::*;
#(
  parameter int NLEV  = 12,
  parameter int CNT_W = 9
) (
  input  logic [CNT_W-1:0]    cnt,
  input  logic                wide,
  input  logic [COL_WIDE-1:0] col_e,
  input  logic [COL_WIDE-1:0] col_o,
  input  logic                wpar,
  output logic [NLEV-1:0]     upd_e,
  output logic [NLEV-1:0]     upd_o
);
  for (genvar L = 0; L < NLEV; L++) begin : g_lev
    if (L < COL_NARROW) begin : g_col
      assign upd_e[L] = col_e[L];
      assign upd_o[L] = col_o[L];
    end else if (L < COL_WIDE) begin : g_split
      assign upd_e[L] = wide ? col_e[L] : (wpar & ~cnt[L-COL_NARROW]);
      assign upd_o[L] = wide ? col_o[L] : (wpar &  cnt[L-COL_NARROW]);
    end else begin : g_row
      logic pos_bit;
      assign pos_bit  = wide ? cnt[L-COL_WIDE] : cnt[L-COL_NARROW];
      assign upd_e[L] = wpar & ~pos_bit;
      assign upd_o[L] = wpar &  pos_bit;
    end
  end
endmodule

// File: rtl/nand_parity_acc.sv
module nand_parity_acc #(
  parameter int NLEV = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            accept,
  input  logic [NLEV-1:0] upd_e,
  input  logic [NLEV-1:0] upd_o,
  output logic [NLEV-1:0] acc_e,
  output logic [NLEV-1:0] acc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_e <= '0;
      acc_o <= '0;
    end else if (clr) begin
      acc_e <= '0;
      acc_o <= '0;
    end else if (accept) begin
      acc_e <= acc_e ^ upd_e;
      acc_o <= acc_o ^ upd_o;
    end
  end

  logic [NLEV-1:0] pair_x;
  assign pair_x = acc_e ^ acc_o;

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !clr) |=> ($stable(acc_e) && $stable(acc_o)));

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_e == '0 && acc_o == '0));

  // R9
  pair_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pair_x) == 0) || ($countones(pair_x) == NLEV));
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  localparam int CNT_W = $clog2(PAGE_BYTES),
  localparam int NLEV  = CNT_W + COL_NARROW,
  localparam int PAR_W = 2 * NLEV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic [BUS_W-1:0] in_data,
  input  logic             wide,
  output logic [PAR_W-1:0] ecc_out
);
  logic                accept;
  logic [CNT_W-1:0]    cnt;
  logic [COL_WIDE-1:0] col_e, col_o;
  logic                wpar;
  logic [NLEV-1:0]     upd_e, upd_o, acc_e, acc_o;

  assign accept = in_valid & ~clr;

  nand_word_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .advance(accept), .cnt(cnt)
  );

  nand_col_parity u_col (
    .data(in_data), .wide(wide), .col_e(col_e), .col_o(col_o), .wpar(wpar)
  );

  nand_level_map #(.NLEV(NLEV), .CNT_W(CNT_W)) u_map (
    .cnt(cnt), .wide(wide), .col_e(col_e), .col_o(col_o), .wpar(wpar),
    .upd_e(upd_e), .upd_o(upd_o)
  );

  nand_parity_acc #(.NLEV(NLEV)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .accept(accept),
    .upd_e(upd_e), .upd_o(upd_o), .acc_e(acc_e), .acc_o(acc_o)
  );

  for (genvar L = 0; L < NLEV; L++) begin : g_pack
    assign ecc_out[2*L]   = acc_e[L];
    assign ecc_out[2*L+1] = acc_o[L];
  end

  // R8
  odd_word_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wpar) |=> ((ecc_out[0] ^ ecc_out[1]) != $past(ecc_out[0] ^ ecc_out[1])));

  // R8
  even_word_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wpar) |=> ((ecc_out[0] ^ ecc_out[1]) == $past(ecc_out[0] ^ ecc_out[1])));
endmodule

// File: tb/tb_nand_ecc_gen.sv
module tb_nand_ecc_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        wide = 1'b0;
  logic [23:0] ecc_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nand_ecc_gen dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_data(in_data), .wide(wide), .ecc_out(ecc_out)
  );

  logic [11:0] m_e = '0, m_o = '0;
  int          m_pos = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [23:0] model_pack();
    logic [23:0] p;
    for (int L = 0; L < 12; L++) begin
      p[2*L]   = m_e[L];
      p[2*L+1] = m_o[L];
    end
    return p;
  endfunction

  task automatic step(input logic v, input logic c, input logic w,
                      input logic [15:0] d, input string tag);
    int wd, a;
    @(negedge clk);
    in_valid = v; clr = c; wide = w; in_data = d;
    if (c) begin
      m_e = '0; m_o = '0; m_pos = 0;
    end else if (v) begin
      wd = w ? 16 : 8;
      for (int i = 0; i < wd; i++) begin
        a = (m_pos * wd + i) % 4096;
        for (int L = 0; L < 12; L++)
          if ((a >> L) % 2 == 1) m_o[L] = m_o[L] ^ d[i];
          else                   m_e[L] = m_e[L] ^ d[i];
      end
      m_pos++;
    end
    exp_q.push_back(model_pack());
    tag_q.push_back(tag);
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin : monitor
    logic [23:0] e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (ecc_out !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, ecc_out, e);
        end
      end
    end
  end

  task automatic idle(input string tag);
    step(1'b0, 1'b0, wide, 16'hA5A5, tag);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check_bit(ecc_out == 24'h0, 1'b1, "R1 reset zero");
    rst_n = 1'b1;

    // R3: single byte, upper byte must be ignored
    step(1'b1, 1'b0, 1'b0, 16'hFF01, "R3 byte bit0");
    step(1'b1, 1'b0, 1'b0, 16'h3C80, "R3 byte bit7");
    // R7: idle cycles hold
    idle("R7 idle hold");
    idle("R7 idle hold");
    // R3 R4: random byte stream
    for (int n = 0; n < 40; n++) step(1'b1, 1'b0, 1'b0, 16'($urandom), "R4 byte rows");
    // R2: clear with valid drops word
    step(1'b1, 1'b1, 1'b0, 16'h00FF, "R2 clear priority");
    step(1'b1, 1'b0, 1'b0, 16'h0001, "R2 restart pos0");
    step(1'b0, 1'b1, 1'b0, 16'h0000, "R2 clear");
    // R5 R6: word mode
    step(1'b1, 1'b0, 1'b1, 16'h8000, "R5 word bit15");
    for (int n = 0; n < 60; n++) step(1'b1, 1'b0, 1'b1, 16'($urandom), "R6 word rows");
    idle("R7 idle word");
    // R9 and R8 covered through the full compare each cycle
    step(1'b0, 1'b1, 1'b0, 16'h0, "R2 clear");
    // R10: 256-byte block
    for (int n = 0; n < 256; n++) step(1'b1, 1'b0, 1'b0, 16'($urandom) | 16'h1, "R10 256 block");
    drain();
    #1;
    check_bit(ecc_out[23], 1'b0, "R10 p2048 odd after 256 bytes");
    step(1'b0, 1'b1, 1'b0, 16'h0, "R2 clear");
    for (int n = 0; n < 128; n++) step(1'b1, 1'b0, 1'b0, 16'($urandom) | 16'h1, "R10 128 block");
    drain();
    #1;
    check_bit(ecc_out[21], 1'b0, "R10 p1024 odd after 128 bytes");
    check_bit(ecc_out[23], 1'b0, "R10 p2048 odd after 128 bytes");
    check_bit(ecc_out[20] ^ ecc_out[21], ecc_out[0] ^ ecc_out[1], "R9 pairs agree");
    // R11: 512 zero bytes then one byte lands at position 0
    step(1'b0, 1'b1, 1'b0, 16'h0, "R2 clear");
    for (int n = 0; n < 512; n++) step(1'b1, 1'b0, 1'b0, 16'h0000, "R11 fill page");
    step(1'b1, 1'b0, 1'b0, 16'h0001, "R11 wrapped byte");
    drain();
    #1;
    check_bit(ecc_out == 24'h555555, 1'b1, "R11 wrap to position 0");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule